// File: doc/BRIEF.md
# Burst Read Word-Address Sequencer

This block produces the sequence of word addresses for a synchronous burst read from a memory array. A start strobe loads the first word address and a 2-bit burst mode. After that, each advance strobe steps a registered address pointer by one word, following the rules of the chosen mode.

Continuous mode walks upward through the whole array and goes back to word zero after the last word. The three wrap modes use an aligned group of 8, 16 or 32 words. In these modes the pointer counts up to the last word of the group, then goes back to the first word of the same group. Only the low group-index bits of the address ever change, so a wrap burst never reaches another 64-word block. A one-cycle flag marks every step that takes the pointer to a lower address.

Control is a three-state machine:
- `ST_IDLE`: the reset state, in which advances are ignored.
- `ST_RUN_LIN`: continuous mode.
- `ST_RUN_WRAP`: one of the group-wrap modes.

The transitions are:
- `ST_IDLE` goes to `ST_RUN_LIN` or `ST_RUN_WRAP` on a start, as the mode selects.
- In either running state, a start moves the machine to the running state that the new mode selects.
- Only reset returns the machine to `ST_IDLE`.

Top module: `burst_addr_seq`

## Requirements
- R1: After reset, `addr_o` is 0 and `wrap_o` is 0.
- R2: A start loads `addr_i` into `addr_o` and clears `wrap_o` on the next clock edge. The mode is latched on the same edge, with the encoding 00 = continuous, 01 = 8-word wrap, 10 = 16-word wrap and 11 = 32-word wrap.
- R3: In continuous mode, an advance below the top of the array adds one to `addr_o`.
- R4: In continuous mode, an advance at address DEPTH-1 sets `addr_o` to 0.
- R5: In a wrap mode with group size N, an advance changes only bits [log2(N)-1:0]. These bits count up from the start value, and after N-1 they return to 0, which is the first word of the group.
- R6: `wrap_o` is 1 for exactly the cycle after an advance that lowers the pointer, and 0 in every other cycle.
- R7: Advances given before the first start leave `addr_o` unchanged.
- R8: A start wins over an advance in the same cycle, and a start during a running burst reloads the pointer at once.
- R9: A change on `mode_i` without a start has no effect on the running sequence.
- R10: In a wrap mode, `addr_o` never leaves its aligned 64-word block.
- R11: A cycle with neither start nor advance holds `addr_o` and leaves `wrap_o` at 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Load the start address and latch the mode |
| mode_i | input | 2 | Burst mode select (see R2) |
| addr_i | input | AW | Start word address |
| adv_i | input | 1 | Step the pointer by one word |
| addr_o | output | AW | Current word address |
| wrap_o | output | 1 | The last step lowered the pointer |

## Verification
A start and an advance can fall in the same cycle. This can happen while the pointer sits on the last word of a group or at the top of the array, where the advance alone would also raise the wrap flag. The bench drives both strobes together at such points. It expects the start address to appear with the wrap flag low, and the scoreboard compares the result cycle by cycle against its own model.

// File: rtl/bseq_pkg.sv
package bseq_pkg;

    typedef enum logic [1:0] {
        BM_CONT   = 2'b00,
        BM_WRAP8  = 2'b01,
        BM_WRAP16 = 2'b10,
        BM_WRAP32 = 2'b11
    } burst_mode_e;

    typedef enum logic [1:0] {
        ST_IDLE     = 2'b00,
        ST_RUN_LIN  = 2'b01,
        ST_RUN_WRAP = 2'b10
    } seq_state_e;

endpackage

// File: rtl/bseq_group_mask.sv
module bseq_group_mask
    import bseq_pkg::*;
#(
    parameter int AW = 12
) (
    input  burst_mode_e     mode_i,
    output logic [AW-1:0]   mask_o
);
    localparam logic [AW-1:0] MASK8  = AW'(7);
    localparam logic [AW-1:0] MASK16 = AW'(15);
    localparam logic [AW-1:0] MASK32 = AW'(31);

    always_comb begin
        unique case (mode_i)
            BM_WRAP8:  mask_o = MASK8;
            BM_WRAP16: mask_o = MASK16;
            BM_WRAP32: mask_o = MASK32;
            default:   mask_o = '0;
        endcase
    end
endmodule

// File: rtl/bseq_step.sv
module bseq_step #(
    parameter int DEPTH = 4096,
    parameter int AW    = 12
) (
    input  logic [AW-1:0] ptr_i,
    input  logic [AW-1:0] mask_i,
    input  logic          wrap_mode_i,
    output logic [AW-1:0] next_o,
    output logic          lowers_o
);
    localparam logic [AW-1:0] TOP_ADDR = AW'(DEPTH - 1);

    logic          at_top;
    logic [AW-1:0] inc;

    generate
        if ((1 << AW) == DEPTH) begin : g_pow2
            assign at_top = &ptr_i;
        end else begin : g_cmp
            assign at_top = (ptr_i == TOP_ADDR);
        end
    endgenerate

    always_comb begin
        inc = ptr_i + AW'(1);
        if (wrap_mode_i) begin
            next_o   = (ptr_i & ~mask_i) | (inc & mask_i);
            lowers_o = ((ptr_i & mask_i) == mask_i);
        end else begin
            next_o   = at_top ? '0 : inc;
            lowers_o = at_top;
        end
    end
endmodule

// File: rtl/bseq_fsm.sv
module bseq_fsm
    import bseq_pkg::*;
(
    input  logic        clk_i,
    input  logic        rst_ni,
    input  logic        start_i,
    input  burst_mode_e mode_i,
    output burst_mode_e mode_q_o,
    output logic        running_o,
    output logic        in_wrap_o
);
    seq_state_e  state_q, state_d;
    burst_mode_e mode_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            state_q <= ST_IDLE;
            mode_q  <= BM_CONT;
        end else begin
            state_q <= state_d;
            if (start_i) mode_q <= mode_i;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE, ST_RUN_LIN, ST_RUN_WRAP: begin
                if (start_i)
                    state_d = (mode_i == BM_CONT) ? ST_RUN_LIN : ST_RUN_WRAP;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        mode_q_o  = mode_q;
        running_o = 1'b0;
        in_wrap_o = 1'b0;
        unique case (state_q)
            ST_RUN_LIN:  running_o = 1'b1;
            ST_RUN_WRAP: begin
                running_o = 1'b1;
                in_wrap_o = 1'b1;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/burst_addr_seq.sv
module burst_addr_seq
    import bseq_pkg::*;
#(
    parameter int DEPTH = 4096,
    parameter int AW    = $clog2(DEPTH)
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic          start_i,
    input  logic [1:0]    mode_i,
    input  logic [AW-1:0] addr_i,
    input  logic          adv_i,
    output logic [AW-1:0] addr_o,
    output logic          wrap_o
);
    burst_mode_e   mode_q;
    logic          running;
    logic          in_wrap;
    logic [AW-1:0] grp_mask;
    logic [AW-1:0] next_addr;
    logic          lowers;
    logic [AW-1:0] addr_q;
    logic          wrap_q;

    bseq_fsm u_fsm (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .start_i   (start_i),
        .mode_i    (burst_mode_e'(mode_i)),
        .mode_q_o  (mode_q),
        .running_o (running),
        .in_wrap_o (in_wrap)
    );

    bseq_group_mask #(.AW(AW)) u_mask (
        .mode_i (mode_q),
        .mask_o (grp_mask)
    );

    bseq_step #(.DEPTH(DEPTH), .AW(AW)) u_step (
        .ptr_i       (addr_q),
        .mask_i      (grp_mask),
        .wrap_mode_i (in_wrap),
        .next_o      (next_addr),
        .lowers_o    (lowers)
    );

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            addr_q <= '0;
            wrap_q <= 1'b0;
        end else if (start_i) begin
            addr_q <= addr_i;
            wrap_q <= 1'b0;
        end else if (adv_i && running) begin
            addr_q <= next_addr;
            wrap_q <= lowers;
        end else begin
            wrap_q <= 1'b0;
        end
    end

    assign addr_o = addr_q;
    assign wrap_o = wrap_q;
endmodule

// File: rtl/bseq_chk.sv
module bseq_chk #(
    parameter int AW = 12
) (
    input logic          clk_i,
    input logic          rst_ni,
    input logic          start_i,
    input logic          adv_i,
    input logic [AW-1:0] addr_i,
    input logic [AW-1:0] addr_o,
    input logic          wrap_o,
    input logic          running,
    input logic          in_wrap,
    input logic [AW-1:0] grp_mask
);
    // R2
    start_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        start_i |=> (addr_o == $past(addr_i)) && !wrap_o);

    // R7
    idle_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!running && !start_i) |=> $stable(addr_o));

    // R11
    no_adv_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!start_i && !adv_i) |=> $stable(addr_o) && !wrap_o);

    // R3
    cont_inc_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (running && !in_wrap && adv_i && !start_i) |=> (wrap_o || (addr_o == $past(addr_o) + AW'(1))));

    // R4
    cont_top_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (running && !in_wrap && adv_i && !start_i) |=> (!wrap_o || (addr_o == '0)));

    // R5
    wrap_upper_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (in_wrap && adv_i && !start_i) |=> ((addr_o & ~$past(grp_mask)) == ($past(addr_o) & ~$past(grp_mask))));

    // R10
    no_cross64_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (in_wrap && adv_i && !start_i) |=> ((addr_o >> 6) == ($past(addr_o) >> 6)));

    // R6
    wrap_down_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (running && adv_i && !start_i) |=> (wrap_o == (addr_o < $past(addr_o))));
endmodule

bind burst_addr_seq bseq_chk #(.AW(AW)) u_chk (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .start_i  (start_i),
    .adv_i    (adv_i),
    .addr_i   (addr_i),
    .addr_o   (addr_o),
    .wrap_o   (wrap_o),
    .running  (running),
    .in_wrap  (in_wrap),
    .grp_mask (grp_mask)
);

// File: tb/burst_addr_seq_bench.sv
module burst_addr_seq_bench;
    localparam int DEPTH = 256;
    localparam int AW    = 8;
    localparam time CLK_P = 8ns;

    logic          clk_i = 1'b0;
    logic          rst_ni = 1'b0;
    logic          start_i = 1'b0;
    logic [1:0]    mode_i = 2'b00;
    logic [AW-1:0] addr_i = '0;
    logic          adv_i = 1'b0;
    logic [AW-1:0] addr_o;
    logic          wrap_o;

    int tests = 0;
    int fails = 0;

    int    q_addr[$];
    bit    q_wrap[$];
    string q_tag[$];

    int m_addr = 0;
    int m_mode = 0;
    bit m_run  = 0;
    bit m_wrap = 0;

    always #(CLK_P/2) clk_i = ~clk_i;

    burst_addr_seq #(.DEPTH(DEPTH)) u_burst_addr_seq (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .start_i(start_i),
        .mode_i (mode_i),
        .addr_i (addr_i),
        .adv_i  (adv_i),
        .addr_o (addr_o),
        .wrap_o (wrap_o)
    );

    task automatic step(input bit st, input int md, input int a, input bit adv, input string tag);
        int n;
        int nxt;
        @(negedge clk_i);
        start_i = st;
        mode_i  = 2'(md);
        addr_i  = AW'(a);
        adv_i   = adv;
        if (st) begin
            m_addr = a; m_mode = md; m_run = 1; m_wrap = 0;
        end else if (adv && m_run) begin
            if (m_mode == 0) begin
                nxt = (m_addr == DEPTH - 1) ? 0 : m_addr + 1;
            end else begin
                n   = 8 << (m_mode - 1);
                nxt = (m_addr - (m_addr % n)) + ((m_addr % n) + 1) % n;
            end
            m_wrap = (nxt < m_addr);
            m_addr = nxt;
        end else begin
            m_wrap = 0;
        end
        q_addr.push_back(m_addr);
        q_wrap.push_back(m_wrap);
        q_tag.push_back(tag);
    endtask

    initial begin : monitor
        forever begin
            @(posedge clk_i);
            #2;
            if (q_addr.size() > 0) begin
                int ea;
                bit ew;
                string t;
                ea = q_addr.pop_front();
                ew = q_wrap.pop_front();
                t  = q_tag.pop_front();
                tests++;
                if (addr_o !== AW'(ea) || wrap_o !== ew) begin
                    fails++;
                    $display("FAIL %s: addr=%0d wrap=%0b expected addr=%0d wrap=%0b",
                             t, addr_o, wrap_o, ea, ew);
                end
            end
        end
    end

    initial begin : watchdog
        #(CLK_P * 100000);
        tests++;
        fails++;
        $display("FAIL watchdog: run did not finish");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin : driver
        repeat (3) @(negedge clk_i);
        rst_ni = 1'b1;
        tests++;
        if (addr_o !== '0 || wrap_o !== 1'b0) begin
            fails++;
            $display("FAIL R1: addr=%0d wrap=%0b expected addr=0 wrap=0", addr_o, wrap_o);
        end
        // R7: advances before any start
        for (int i = 0; i < 4; i++) step(0, 1, 77, 1, "R7");
        // R3 / R4 / R6: continuous near the top of the array
        step(1, 0, 250, 0, "R2");
        for (int i = 0; i < 9; i++) step(0, 0, 0, 1, "R4");
        // R11: hold without advance
        for (int i = 0; i < 3; i++) step(0, 0, 0, 0, "R11");
        for (int i = 0; i < 3; i++) step(0, 0, 0, 1, "R3");
        // R5: 8-word wrap from an odd start
        step(1, 1, 8'h13, 0, "R2");
        for (int i = 0; i < 12; i++) step(0, 1, 0, 1, "R5");
        // R9: mode_i changes without a start
        for (int i = 0; i < 6; i++) step(0, 3, 0, 1, "R9");
        // R5 16-word wrap
        step(1, 2, 8'h2B, 0, "R2");
        for (int i = 0; i < 20; i++) step(0, 2, 0, 1, "R5");
        // R10: 32-word wrap in the upper half of a 64-word block
        step(1, 3, 8'h7D, 0, "R2");
        for (int i = 0; i < 40; i++) step(0, 0, 0, 1, "R10");
        // R8: start and advance in the same cycle at a group end
        step(1, 1, 8'h0F, 0, "R2");
        step(1, 0, 8'hFF, 1, "R8");
        step(0, 0, 0, 1, "R6");
        step(1, 2, 8'h40, 1, "R8");
        for (int i = 0; i < 5; i++) step(0, 0, 0, 1, "R5");
        step(1, 0, 8'h10, 1, "R8");
        step(0, 0, 0, 1, "R3");
        step(0, 0, 0, 0, "R11");
        repeat (3) @(negedge clk_i);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule